// File: doc/BRIEF.md
# CAN Bus Resynchronization Detector

This block decides when a CAN node that has lost its place in the bit stream may take part in bus traffic again. That happens when the node leaves a standby state or recovers from bus-off. On every bit-time strobe it looks at the sampled receive level and counts runs of recessive bits. Each unbroken run of eleven recessive bits counts as one completed sequence.

Resynchronization usually needs 128 completed sequences. A shorter path applies when a fast-resync enable is set and the node is not bus-off: then one completed sequence is enough. A start-resync request clears all progress and begins a new search. Once the synchronized flag asserts, it stays asserted, and the sequence count stays frozen, until the next request. The sequence count is also brought out as a debug value.

Top module: `can_resync_detect`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears seq_count to 0 and deasserts synced at that edge.
- R2: A bit time is a cycle with bit_tick high. A recessive level is rx_level=1. At the edge that samples the 11th consecutive recessive bit time, seq_count increases by one and the run count restarts from zero. A run of 22 recessive bit times therefore counts as two sequences.
- R3: A dominant bit time (rx_level=0) clears the recessive run. seq_count keeps its value, and a fresh run of 11 recessive bit times is needed before the next increment.
- R4: Cycles with bit_tick low change neither seq_count nor the recessive run.
- R5: When fast_en=0 or bus_off=1, synced asserts at the same edge at which seq_count reaches 128, and not before.
- R6: When fast_en=1 and bus_off=0, synced asserts at the edge at which seq_count reaches 1. If that condition becomes true while seq_count is already 1 or more, synced asserts at the next clock edge.
- R7: While synced is high and no request is present, synced stays high and seq_count holds its value, whatever bit_tick and rx_level do.
- R8: start_req high at a clock edge clears seq_count and the run, and deasserts synced. It takes priority over a bit time sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe, one per bit time |
| rx_level | input | 1 | Sampled bus level: 1 recessive, 0 dominant |
| bus_off | input | 1 | Node is in the bus-off state |
| fast_en | input | 1 | Allows single-sequence resynchronization |
| start_req | input | 1 | Restarts the resynchronization search |
| synced | output | 1 | Resynchronization complete (registered) |
| seq_count | output | 8 | Completed recessive sequences (registered) |

## Verification
Both outputs are registered, and both are due at the clock edge that samples the stimulus: the 11th recessive bit time, the request, the reset, or a mode change that lowers the threshold below the count already held. The driver applies each cycle's inputs at the falling edge and queues the output values expected after the next rising edge. The monitor pops one item per rising edge and compares it 2 ns after that edge, so every result is checked in its due cycle. Cycles without a strobe are also queued, so an early or late change is caught as a mismatch.

// File: rtl/can_resync_pkg.sv
package can_resync_pkg;
  typedef enum logic {
    LVL_DOMINANT  = 1'b0,
    LVL_RECESSIVE = 1'b1
  } bus_level_e;

  // Number of bits needed to hold values 0..n
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/resync_run_counter.sv
module resync_run_counter
  import can_resync_pkg::*;
#(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  input  logic level,
  output logic seq_done
);
  localparam int unsigned RUN_W = width_for(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;
  logic             is_rec;

  assign is_rec   = (bus_level_e'(level) == LVL_RECESSIVE);
  assign seq_done = enable && is_rec && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q <= '0;
    end else if (enable) begin
      if (!is_rec || seq_done) begin
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/resync_seq_counter.sv
module resync_seq_counter #(
  parameter int unsigned SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [SEQ_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (inc && (count != {SEQ_W{1'b1}})) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/resync_decide.sv
module resync_decide #(
  parameter int unsigned SEQ_W    = 8,
  parameter int unsigned FULL_SEQ = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             seq_done,
  input  logic [SEQ_W-1:0] count,
  input  logic             fast_en,
  input  logic             bus_off,
  output logic             synced
);
  localparam logic [SEQ_W:0] FULL_T = (SEQ_W+1)'(FULL_SEQ);
  localparam logic [SEQ_W:0] FAST_T = (SEQ_W+1)'(1);

  logic [SEQ_W:0] target;
  logic [SEQ_W:0] next_cnt;
  logic           reach;

  assign target   = (fast_en && !bus_off) ? FAST_T : FULL_T;
  assign next_cnt = {1'b0, count} + {{SEQ_W{1'b0}}, seq_done};
  assign reach    = (next_cnt >= target);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      synced <= 1'b0;
    end else if (reach) begin
      synced <= 1'b1;
    end
  end
endmodule

// File: rtl/can_resync_detect.sv
module can_resync_detect
  import can_resync_pkg::*;
#(
  parameter int unsigned RUN_LEN  = 11,
  parameter int unsigned FULL_SEQ = 128,
  localparam int unsigned SEQ_W   = width_for(FULL_SEQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             rx_level,
  input  logic             bus_off,
  input  logic             fast_en,
  input  logic             start_req,
  output logic             synced,
  output logic [SEQ_W-1:0] seq_count
);
  logic run_en;
  logic seq_done;

  // Counting stops once synchronized; a request overrides a bit time
  assign run_en = bit_tick && !synced && !start_req;

  resync_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .clear    (start_req),
    .enable   (run_en),
    .level    (rx_level),
    .seq_done (seq_done)
  );

  resync_seq_counter #(.SEQ_W(SEQ_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .clear (start_req),
    .inc   (seq_done),
    .count (seq_count)
  );

  resync_decide #(.SEQ_W(SEQ_W), .FULL_SEQ(FULL_SEQ)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .clear    (start_req),
    .seq_done (seq_done),
    .count    (seq_count),
    .fast_en  (fast_en),
    .bus_off  (bus_off),
    .synced   (synced)
  );
endmodule

// File: rtl/can_resync_detect_chk.sv
module can_resync_detect_chk #(
  parameter int unsigned FULL_SEQ = 128,
  parameter int unsigned SEQ_W    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_tick,
  input logic             start_req,
  input logic             synced,
  input logic [SEQ_W-1:0] seq_count
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!synced && seq_count == '0));

  // R8
  request_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (!synced && seq_count == '0));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !start_req) |=> $stable(seq_count));

  // R7
  sticky_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (synced && !start_req) |=> (synced && $stable(seq_count)));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    seq_count <= SEQ_W'(FULL_SEQ));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_req && !synced) |=>
      (seq_count == $past(seq_count) || seq_count == $past(seq_count) + 1'b1));
endmodule

bind can_resync_detect can_resync_detect_chk #(
  .FULL_SEQ(FULL_SEQ),
  .SEQ_W   (SEQ_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_tick  (bit_tick),
  .start_req (start_req),
  .synced    (synced),
  .seq_count (seq_count)
);

// File: tb/can_resync_detect_test.sv
`timescale 1ns/1ps
module can_resync_detect_test;
  localparam int RUN = 11;
  localparam int FULL = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       rx_level = 1'b1;
  logic       bus_off = 1'b0;
  logic       fast_en = 1'b0;
  logic       start_req = 1'b0;
  logic       synced;
  logic [7:0] seq_count;

  always #4 clk = ~clk;

  can_resync_detect uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_level(rx_level),
    .bus_off(bus_off), .fast_en(fast_en), .start_req(start_req),
    .synced(synced), .seq_count(seq_count)
  );

  typedef struct {
    logic       sync;
    logic [7:0] cnt;
    string      tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int  m_run = 0;
  int  m_cnt = 0;
  bit  m_sync = 0;
  bit  mode_fast = 0;
  bit  mode_boff = 0;

  task automatic drive(bit r, bit st, bit tk, bit lv, string tag);
    exp_t e;
    int tgt;
    @(negedge clk);
    rst = r; start_req = st; bit_tick = tk; rx_level = lv;
    fast_en = mode_fast; bus_off = mode_boff;
    if (r || st) begin
      m_run = 0; m_cnt = 0; m_sync = 0;
    end else begin
      tgt = (mode_fast && !mode_boff) ? 1 : FULL;
      if (!m_sync) begin
        if (tk) begin
          if (!lv) m_run = 0;
          else if (m_run == RUN - 1) begin m_run = 0; m_cnt++; end
          else m_run++;
        end
        if (m_cnt >= tgt) m_sync = 1;
      end
    end
    e.sync = m_sync; e.cnt = 8'(m_cnt); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic bits(int n, bit lv, string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 1, lv, tag);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        #2;
        e = q.pop_front();
        compared++;
        if (synced !== e.sync || seq_count !== e.cnt) begin
          mismatched++;
          $display("FAIL %s: synced=%0b seq_count=%0d expected synced=%0b seq_count=%0d",
                   e.tag, synced, seq_count, e.sync, e.cnt);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    drive(1, 0, 0, 1, "R1");
    drive(1, 0, 1, 1, "R1");
    // Fast path, not bus-off
    mode_fast = 1; mode_boff = 0;
    drive(0, 1, 0, 1, "R8");
    for (int i = 0; i < 10; i++) begin
      drive(0, 0, 1, 1, "R2");
      drive(0, 0, 0, 0, "R4");
    end
    bits(1, 0, "R3");
    bits(10, 1, "R3");
    bits(1, 1, "R6");
    bits(6, 0, "R7");
    bits(30, 1, "R7");
    drive(0, 1, 1, 1, "R8");
    // Bus-off forces the long threshold
    mode_boff = 1;
    bits(22, 1, "R2");
    bits(5, 1, "R3");
    bits(1, 0, "R3");
    bits(RUN * (FULL - 2) - 1, 1, "R5");
    bits(1, 1, "R5");
    bits(12, 1, "R7");
    drive(0, 1, 0, 1, "R8");
    // Long threshold, then threshold lowered with count already held
    mode_boff = 0; mode_fast = 0;
    bits(RUN, 1, "R5");
    drive(0, 0, 0, 1, "R4");
    mode_fast = 1;
    drive(0, 0, 0, 1, "R6");
    drive(0, 1, 0, 1, "R8");
    // Full run with fast disabled
    mode_fast = 0;
    bits(RUN * FULL - 1, 1, "R5");
    bits(1, 1, "R5");
    bits(3, 0, "R7");
    drive(1, 0, 0, 1, "R1");
    drive(0, 0, 0, 1, "R4");
    repeat (4) @(posedge clk);
    #3;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule